// File: doc/BRIEF.md
# Regulator Startup Sequencer and Fault Latch

This block orders the start of a voltage regulator controller and shuts it down when something goes wrong. It waits for the supplies to become ready and spends a fixed calibration time. It then either ramps the regulation target up to a boot voltage or, when the boot voltage is zero, parks at zero. Power-good rises in the same cycle as a one-cycle alert pulse. After that, the target follows the commanded voltage.

Three protections watch digitized comparator flags, each through its own deglitch timer: overvoltage, undervoltage and overcurrent. Overcurrent comes in two forms, the summed output current and a per-phase channel limit. A qualified fault latches the block off. The gate drivers are then held in a state that depends on the fault type, and a fault code records the cause. Only taking the power-ready input low releases the latch. A separate current-alert flag is passed through while the block regulates and never latches.

Top module: `vr_seq_guard`

## Requirements
- R1: While `por` is low, the outputs are `dac_sel`=00 (zero target), `gate_mode`=00 (all switches off), `pgood`=0, `alert`=0 and `fault_code`=00. The same values hold out of reset.
- R2: After `por` is seen high, the block calibrates for CAL_CYC cycles with the R1 outputs. It then enters the boot ramp, with `dac_sel`=01 (boot target), `gate_mode`=01 (switching) and `pgood`=0.
- R3: When `ramp_done` is high during the boot ramp, the next cycle shows `dac_sel`=10 (commanded VID plus offset), `gate_mode`=01 and `pgood`=1. `alert` is high for exactly the first cycle of `pgood`.
- R4: With `vboot_zero` high, calibration is followed by a wait state. In that state `pgood`=1, `alert` pulses once, `dac_sel`=00 and `gate_mode`=00. A `setvid_req` moves the block to regulation (`dac_sel`=10, `gate_mode`=01) with no second alert.
- R5: A fault qualifies only after its flag has been high for its full delay in consecutive cycles. Dropping the flag for even one cycle restarts that delay from zero.
- R6: Overvoltage qualifies after OV_US microseconds (CLK_PER_US cycles each). It sets `fault_code`=01 and `gate_mode`=10 (low-side on, high-side off).
- R7: Undervoltage qualifies after UV_US microseconds and sets `fault_code`=11 and `gate_mode`=00. It is ignored until `ramp_done` has been seen while ramping or regulating.
- R8: Total overcurrent (OC_US) and channel overcurrent (CH_US) each set `fault_code`=10 and `gate_mode`=11 (high impedance). `pgood` drops in the same cycle as the latch.
- R9: Faults that qualify in the same cycle are ranked overvoltage first, then overcurrent, then undervoltage.
- R10: A latched fault keeps its code and gate mode while `por` stays high, whatever the flags do. `por` low returns the block to the R1 state.
- R11: `icc_alert` follows `icc_flag` while the block ramps, waits or regulates, and it has no effect on `pgood` or the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| por | input | 1 | Supplies ready; low clears everything |
| vboot_zero | input | 1 | Boot voltage is programmed to zero |
| ramp_done | input | 1 | Soft-start output has reached its target |
| setvid_req | input | 1 | A set-voltage command has arrived |
| ov_flag | input | 1 | Overvoltage comparator |
| uv_flag | input | 1 | Undervoltage comparator |
| oc_flag | input | 1 | Total overcurrent comparator |
| chan_oc_flag | input | 1 | Per-channel overcurrent comparator |
| icc_flag | input | 1 | Current-sense at maximum-current alert level |
| dac_sel | output | 2 | Target: 00 zero, 01 boot, 10 commanded |
| pgood | output | 1 | Power good |
| alert | output | 1 | One-cycle alert pulse on power-good rise |
| icc_alert | output | 1 | Non-latching current alert |
| gate_mode | output | 2 | 00 off, 01 switching, 10 low-side on, 11 high impedance |
| fault_code | output | 2 | 00 none, 01 OV, 10 OC, 11 UV |

## Verification
The start sequence is run twice: once with a nonzero boot voltage through the ramp, and once with a zero boot voltage through the wait state. This separates the point where power-good rises from the point where the target changes. Each fault flag is held for exactly one cycle less than its delay and then for the full delay. A flag that drops one cycle short and is then raised again shows that the timer restarts rather than accumulates. Undervoltage is raised during the ramp and again after it, to show it is armed only once the boot voltage is reached. Simultaneous flags show the ranking. Flags toggled after a latch, followed by a `por` drop, show that the latch holds and then clears.

// File: rtl/vr_seq_guard.sv
module vr_seq_guard #(
  parameter int CLK_PER_US = 8,
  parameter int CAL_CYC    = 16,
  parameter int OV_US      = 20,
  parameter int UV_US      = 5,
  parameter int OC_US      = 20,
  parameter int CH_US      = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por,
  input  logic       vboot_zero,
  input  logic       ramp_done,
  input  logic       setvid_req,
  input  logic       ov_flag,
  input  logic       uv_flag,
  input  logic       oc_flag,
  input  logic       chan_oc_flag,
  input  logic       icc_flag,
  output logic [1:0] dac_sel,
  output logic       pgood,
  output logic       alert,
  output logic       icc_alert,
  output logic [1:0] gate_mode,
  output logic [1:0] fault_code
);

  localparam int LSUM = (OV_US + UV_US + OC_US + CH_US) * CLK_PER_US;
  localparam int CW   = $clog2(LSUM + 1);
  localparam int CALW = $clog2(CAL_CYC + 1);
  localparam int LIM [4] = '{OV_US * CLK_PER_US, OC_US * CLK_PER_US,
                             CH_US * CLK_PER_US, UV_US * CLK_PER_US};

  typedef enum logic [2:0] {S_OFF, S_CAL, S_RAMP, S_WAIT0, S_RUN, S_FAULT} st_t;

  localparam logic [1:0] F_NONE = 2'b00, F_OV = 2'b01, F_OC = 2'b10, F_UV = 2'b11;

  st_t st, nxt;
  logic [CALW-1:0] cal;
  logic            uv_arm, pg_d;
  logic [1:0]      fault_q, new_code;
  logic [3:0]      flg, en, trip;
  logic            mon;

  assign mon = (st == S_RAMP) || (st == S_WAIT0) || (st == S_RUN);
  assign flg = {uv_flag, chan_oc_flag, oc_flag, ov_flag};
  assign en  = {mon && uv_arm, mon, mon, mon};

  for (genvar i = 0; i < 4; i++) begin : g_dg
    logic [CW-1:0] cnt;
    assign trip[i] = flg[i] && en[i] && (cnt == CW'(LIM[i] - 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (!flg[i] || !en[i])  cnt <= '0;
      else if (!trip[i])           cnt <= cnt + 1'b1;
    end
  end

  assign new_code = trip[0]             ? F_OV :
                    (trip[1] | trip[2]) ? F_OC :
                    trip[3]             ? F_UV : F_NONE;

  always_comb begin
    nxt = st;
    case (st)
      S_OFF:   if (por) nxt = S_CAL;
      S_CAL:   if (cal == CALW'(CAL_CYC - 1)) nxt = vboot_zero ? S_WAIT0 : S_RAMP;
      S_RAMP:  if (ramp_done) nxt = S_RUN;
      S_WAIT0: if (setvid_req) nxt = S_RUN;
      default: nxt = st;
    endcase
    if (mon && (|trip)) nxt = S_FAULT;
    if (!por) nxt = S_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_OFF;
      cal     <= '0;
      uv_arm  <= 1'b0;
      fault_q <= F_NONE;
      pg_d    <= 1'b0;
    end else begin
      st   <= nxt;
      pg_d <= pgood;
      cal  <= (st == S_CAL) ? cal + 1'b1 : '0;
      if (!por)                                         uv_arm <= 1'b0;
      else if (ramp_done && (st == S_RAMP || st == S_RUN)) uv_arm <= 1'b1;
      if (!por)                      fault_q <= F_NONE;
      else if (mon && (|trip))       fault_q <= new_code;
    end
  end

  assign pgood      = (st == S_RUN) || (st == S_WAIT0);
  assign alert      = pgood && !pg_d;
  assign icc_alert  = mon && icc_flag;
  assign fault_code = fault_q;
  assign dac_sel    = (st == S_RAMP) ? 2'b01 : (st == S_RUN) ? 2'b10 : 2'b00;

  always_comb begin
    case (st)
      S_RAMP, S_RUN: gate_mode = 2'b01;
      S_FAULT:       gate_mode = (fault_q == F_OV) ? 2'b10 :
                                 (fault_q == F_UV) ? 2'b00 : 2'b11;
      default:       gate_mode = 2'b00;
    endcase
  end

  // R1
  por_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !por |=> (st == S_OFF && fault_code == F_NONE));
  // R3
  alert_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alert |=> !alert);
  // R7
  uv_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RAMP) |=> fault_code != F_UV);
  // R6
  ov_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FAULT && fault_code == F_OV) |-> gate_mode == 2'b10);
  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FAULT && por) |=> (st == S_FAULT && $stable(fault_code)));
  // R8
  fault_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != F_NONE) |-> !pgood);

endmodule

// File: tb/vr_seq_guard_test.sv
module vr_seq_guard_test;
  localparam int CPU = 8, CAL = 16;
  localparam int OV_L = 20 * CPU, UV_L = 5 * CPU, OC_L = 20 * CPU, CH_L = 5 * CPU;

  logic clk = 0, rst_n = 0, por = 0, vboot_zero = 0, ramp_done = 0, setvid_req = 0;
  logic ov_flag = 0, uv_flag = 0, oc_flag = 0, chan_oc_flag = 0, icc_flag = 0;
  logic [1:0] dac_sel, gate_mode, fault_code;
  logic pgood, alert, icc_alert;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  vr_seq_guard #(.CLK_PER_US(CPU), .CAL_CYC(CAL)) uut (
    .clk(clk), .rst_n(rst_n), .por(por), .vboot_zero(vboot_zero), .ramp_done(ramp_done),
    .setvid_req(setvid_req), .ov_flag(ov_flag), .uv_flag(uv_flag), .oc_flag(oc_flag),
    .chan_oc_flag(chan_oc_flag), .icc_flag(icc_flag), .dac_sel(dac_sel), .pgood(pgood),
    .alert(alert), .icc_alert(icc_alert), .gate_mode(gate_mode), .fault_code(fault_code));

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(logic vz);
    por = 0; vboot_zero = vz;
    {ov_flag, uv_flag, oc_flag, chan_oc_flag, icc_flag, ramp_done, setvid_req} = '0;
    cyc(2);
    por = 1;
    cyc(CAL + 1);
  endtask

  task automatic to_run();
    start(0);
    ramp_done = 1; cyc(1); ramp_done = 0;
  endtask

  task automatic t_reset();
    chk("R1", dac_sel, 0, "dac_sel"); chk("R1", gate_mode, 0, "gate_mode");
    chk("R1", pgood, 0, "pgood"); chk("R1", alert, 0, "alert");
    chk("R1", fault_code, 0, "fault_code");
    rst_n = 1; cyc(3);
    chk("R1", gate_mode, 0, "gate stays off while por low");
  endtask

  task automatic t_boot();
    por = 0; vboot_zero = 0; cyc(2);
    por = 1; cyc(CAL);
    chk("R2", gate_mode, 0, "still calibrating");
    chk("R2", dac_sel, 0, "dac during calibration");
    cyc(1);
    chk("R2", gate_mode, 1, "ramp switching"); chk("R2", dac_sel, 1, "boot target");
    chk("R2", pgood, 0, "no pgood while ramping");
    ramp_done = 1; cyc(1); ramp_done = 0;
    chk("R3", pgood, 1, "pgood after ramp"); chk("R3", alert, 1, "alert with pgood");
    chk("R3", dac_sel, 2, "commanded target");
    cyc(1);
    chk("R3", alert, 0, "alert one cycle");
  endtask

  task automatic t_zero_boot();
    start(1);
    chk("R4", pgood, 1, "pgood in zero wait"); chk("R4", alert, 1, "alert in zero wait");
    chk("R4", dac_sel, 0, "zero target"); chk("R4", gate_mode, 0, "gate off in wait");
    cyc(3);
    chk("R4", dac_sel, 0, "still waiting");
    setvid_req = 1; cyc(1); setvid_req = 0;
    chk("R4", dac_sel, 2, "commanded after setvid"); chk("R4", gate_mode, 1, "switching");
    chk("R4", alert, 0, "no second alert");
  endtask

  task automatic t_ov();
    to_run();
    ov_flag = 1; cyc(OV_L - 1);
    chk("R6", fault_code, 0, "ov one short"); chk("R6", pgood, 1, "pgood before ov");
    cyc(1);
    chk("R6", fault_code, 1, "ov code"); chk("R6", gate_mode, 2, "low side on");
    chk("R6", pgood, 0, "pgood after ov");
    ov_flag = 0; oc_flag = 1; uv_flag = 1; cyc(OC_L + 5);
    chk("R10", fault_code, 1, "latched code held"); chk("R10", gate_mode, 2, "latched gate held");
    oc_flag = 0; uv_flag = 0;
    por = 0; cyc(1);
    chk("R10", fault_code, 0, "por low clears"); chk("R10", gate_mode, 0, "por low gate off");
  endtask

  task automatic t_uv();
    start(0);
    uv_flag = 1; cyc(UV_L + 20);
    chk("R7", fault_code, 0, "uv ignored in ramp"); chk("R7", gate_mode, 1, "still ramping");
    uv_flag = 0; ramp_done = 1; cyc(1); ramp_done = 0;
    uv_flag = 1; cyc(UV_L - 1);
    chk("R7", fault_code, 0, "uv one short");
    cyc(1);
    chk("R7", fault_code, 3, "uv code"); chk("R7", gate_mode, 0, "all off");
  endtask

  task automatic t_oc();
    to_run();
    icc_flag = 1; cyc(1);
    chk("R11", icc_alert, 1, "icc alert follows");
    icc_flag = 0; cyc(1);
    chk("R11", icc_alert, 0, "icc alert drops"); chk("R11", pgood, 1, "pgood kept");
    oc_flag = 1; cyc(OC_L - 1); oc_flag = 0; cyc(1);
    chk("R5", fault_code, 0, "glitch one short");
    oc_flag = 1; cyc(OC_L - 1);
    chk("R5", fault_code, 0, "timer restarted");
    cyc(1);
    chk("R8", fault_code, 2, "oc code"); chk("R8", gate_mode, 3, "high impedance");
    chk("R8", pgood, 0, "pgood dropped");
    oc_flag = 0;
    to_run();
    chan_oc_flag = 1; cyc(CH_L - 1);
    chk("R8", fault_code, 0, "chan oc one short");
    cyc(1);
    chk("R8", fault_code, 2, "chan oc code"); chk("R8", gate_mode, 3, "chan oc hiz");
    chan_oc_flag = 0;
  endtask

  task automatic t_prio();
    to_run();
    ov_flag = 1; oc_flag = 1; cyc(OV_L);
    chk("R9", fault_code, 1, "ov beats oc"); chk("R9", gate_mode, 2, "ov gate wins");
    ov_flag = 0; oc_flag = 0;
    to_run();
    uv_flag = 1; chan_oc_flag = 1; cyc(UV_L);
    chk("R9", fault_code, 2, "oc beats uv"); chk("R9", gate_mode, 3, "oc gate wins");
    uv_flag = 0; chan_oc_flag = 0;
  endtask

  initial begin
    cyc(2);
    t_reset();
    t_boot();
    t_zero_boot();
    t_ov();
    t_uv();
    t_oc();
    t_prio();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule